// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block sits beside a local bus master and times each write cycle that the master sends to an attached peripheral. A peripheral can stretch a cycle by holding its active-low wait line, and a faulty or stalled device can hold it forever. The monitor counts clock edges for as long as a cycle is open. It sets a sticky timeout flag when one cycle runs past a fixed limit, by default 64 clocks. In the same clock it sends a one-clock abort pulse so the master can end the stuck cycle.

Host software reads the flag as a status bit and clears it by writing a one to that bit. A write of zero leaves the flag alone. If a hardware timeout and a host clear land on the same clock edge, the timeout wins and the flag stays set. A parameter chooses the counting rule: either every clock of an open cycle counts, or only clocks in which the wait line is held.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: While reset is asserted (`rst_n` low) and on the first clock after it is released, `timeout_flag` is 0, `abort` is 0 and `elapsed` is 0.
- R2: `elapsed` is 0 after any clock edge that samples `cyc_active` low. It rises by one on each edge that samples `cyc_active` high, so each new cycle counts again from zero, and it saturates at LIMIT+1.
- R3: A cycle that is still active, with `wait_n` low, at its (LIMIT+1)-th sampled clock edge sets `timeout_flag` to 1 right after that edge.
- R4: A cycle whose `cyc_active` stays high for exactly LIMIT clock edges and then drops never sets `timeout_flag`.
- R5: When a timeout occurs, `abort` is 1 for exactly the one clock after the triggering edge. It rises at most once per cycle, even if the cycle stays open afterwards.
- R6: A host write (`host_wr` high) with `host_wdata` 1 clears `timeout_flag` at the next edge, provided no timeout occurs on that edge.
- R7: A host write with `host_wdata` 0, or no host write at all, leaves `timeout_flag` unchanged.
- R8: When a timeout and a host clear happen on the same edge, `timeout_flag` ends up 1.
- R9: If `wait_n` is high on the edge where the count reaches the limit, no timeout is raised for that cycle. The count saturates and cannot trigger a timeout later in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_active | input | 1 | High while the master has a write cycle open |
| wait_n | input | 1 | Active-low wait line driven by the addressed device |
| host_wr | input | 1 | Host write strobe to the status bit |
| host_wdata | input | 1 | Value the host writes to the status bit (1 clears) |
| timeout_flag | output | 1 | Sticky timeout status |
| abort | output | 1 | One-clock request to end the current cycle |
| elapsed | output | $clog2(LIMIT+2) | Clocks counted in the current cycle |

## Verification
The assertions take for granted that the master lowers `cyc_active` for at least one clock between two cycles; otherwise the monitor sees two cycles as one. They also take for granted that host writes and bus activity arrive as plain synchronous levels sampled on the rising edge. The stimulus drives every input a short time after a rising edge and always inserts an idle clock between cycles. Host clears are placed both in idle time and exactly on the edge where the limit is crossed, so the set-wins rule is exercised.

// File: rtl/bctm_pkg.sv
package bctm_pkg;
   // How clocks of an open cycle are counted.
   typedef enum logic {
      CNT_ALL_ACTIVE = 1'b0,   // every clock of an open cycle counts
      CNT_WAIT_ONLY  = 1'b1    // only clocks with the wait line held count
   } cnt_mode_e;

   function automatic int unsigned count_width(input int unsigned limit);
      return $clog2(limit + 2);
   endfunction
endpackage

// File: rtl/bctm_cycle_timer.sv
module bctm_cycle_timer
   import bctm_pkg::*;
#(
   parameter int unsigned LIMIT = 64,
   parameter cnt_mode_e   MODE  = CNT_ALL_ACTIVE,
   parameter int unsigned CNT_W = count_width(LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_active,
   input  logic             wait_n,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] SAT_C = CNT_W'(LIMIT + 1);

   logic advance;

   generate
      if (MODE == CNT_WAIT_ONLY) begin : g_wait_only
         assign advance = ~wait_n;
      end else begin : g_all_active
         assign advance = 1'b1;
      end
   endgenerate

   // Crossing the limit counts only while the device still stretches the cycle.
   assign expire = cyc_active & ~wait_n & (count == LIM_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (!cyc_active) begin
         count <= '0;
      end else if (count == SAT_C) begin
         count <= count;
      end else if (expire) begin
         count <= SAT_C;
      end else if (advance) begin
         count <= count + 1'b1;
      end
   end

   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_active |=> (count == '0));

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= SAT_C);

   assert_single_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
endmodule

// File: rtl/bctm_sticky_w1c.sv
module bctm_sticky_w1c (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_data,
   output logic flag
);
   logic sw_clear;
   assign sw_clear = sw_wr & sw_data;

   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (hw_set)  flag <= 1'b1;
      else if (sw_clear) flag <= 1'b0;
   end

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag);

   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && sw_wr && sw_data && !hw_set) |=> !flag);

   assert_zero_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(sw_wr && sw_data)) |=> flag);
endmodule

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog
   import bctm_pkg::*;
#(
   parameter int unsigned LIMIT = 64,
   parameter cnt_mode_e   MODE  = CNT_ALL_ACTIVE,
   localparam int unsigned CNT_W = count_width(LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_active,
   input  logic             wait_n,
   input  logic             host_wr,
   input  logic             host_wdata,
   output logic             timeout_flag,
   output logic             abort,
   output logic [CNT_W-1:0] elapsed
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("LIMIT must be at least 1");
      end
   endgenerate

   logic expire;

   bctm_cycle_timer #(
      .LIMIT (LIMIT),
      .MODE  (MODE),
      .CNT_W (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_active (cyc_active),
      .wait_n     (wait_n),
      .count      (elapsed),
      .expire     (expire)
   );

   bctm_sticky_w1c u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (expire),
      .sw_wr   (host_wr),
      .sw_data (host_wdata),
      .flag    (timeout_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) abort <= 1'b0;
      else        abort <= expire;
   end

   assert_abort_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !abort);

   assert_abort_with_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> timeout_flag);

   assert_abort_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort) |-> (elapsed == CNT_W'(LIMIT + 1)) || !$past(cyc_active));
endmodule

// File: tb/sim_bus_cycle_watchdog.sv
`timescale 1ns/1ps
module sim_bus_cycle_watchdog;
   localparam int LIMIT = 64;
   localparam int CW    = $clog2(LIMIT + 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_active = 1'b0, wait_n = 1'b1, host_wr = 1'b0, host_wdata = 1'b0;
   logic timeout_flag, abort;
   logic [CW-1:0] elapsed;

   always #10 clk = ~clk;

   bus_cycle_watchdog #(.LIMIT(LIMIT)) u0 (
      .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active), .wait_n(wait_n),
      .host_wr(host_wr), .host_wdata(host_wdata),
      .timeout_flag(timeout_flag), .abort(abort), .elapsed(elapsed)
   );

   typedef struct {
      logic  f;
      logic  a;
      int    e;
      int    due;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0, errors = 0, edges = 0;
   int m_cnt = 0;
   logic m_flag = 1'b0, m_abort = 1'b0;

   always @(posedge clk) edges <= edges + 1;

   task automatic compare(input logic f, input logic a, input int e, input string tag);
      checks++;
      if (timeout_flag !== f || abort !== a || int'(elapsed) != e) begin
         errors++;
         $display("FAIL %s: flag/abort/elapsed actual %b/%b/%0d expected %b/%b/%0d",
                  tag, timeout_flag, abort, elapsed, f, a, e);
      end
   endtask

   // Monitor: pops each expected item once its clock edge has passed.
   always begin
      @(posedge clk);
      #5;
      while (q.size() > 0 && q[0].due <= edges) begin
         exp_t it;
         it = q.pop_front();
         compare(it.f, it.a, it.e, it.tag);
      end
   end

   // Driver: applies one clock of stimulus and queues the expected result.
   task automatic step(input logic act, input logic wn, input logic hw,
                       input logic hd, input string tag);
      exp_t it;
      logic fire;
      @(posedge clk);
      #2;
      cyc_active = act; wait_n = wn; host_wr = hw; host_wdata = hd;
      fire = act && !wn && (m_cnt == LIMIT);
      if (!act)                   m_cnt = 0;
      else if (m_cnt == LIMIT + 1) m_cnt = m_cnt;
      else                        m_cnt = m_cnt + 1;
      if (fire)             m_flag = 1'b1;
      else if (hw && hd)    m_flag = 1'b0;
      m_abort = fire;
      it.f = m_flag; it.a = m_abort; it.e = m_cnt; it.due = edges + 1; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0, tag);
   endtask

   initial begin
      // R1: state held in reset
      repeat (3) @(posedge clk);
      #5;
      compare(1'b0, 1'b0, 0, "R1");
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      idle(2, "R1");

      // R2: short cycle, then back-to-back cycles restart from zero
      for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
      idle(1, "R2");
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
      idle(1, "R2");
      for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
      idle(2, "R2");

      // R4: exactly LIMIT clocks does not time out
      for (int i = 0; i < LIMIT; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R4");
      idle(3, "R4");

      // R9: wait released at the limit edge, cycle held on afterwards
      for (int i = 0; i < LIMIT + 8; i++)
         step(1'b1, (i >= LIMIT - 4), 1'b0, 1'b0, "R9");
      idle(2, "R9");

      // R3 / R5: stuck cycle times out, abort pulses once
      for (int i = 0; i < LIMIT + 8; i++)
         step(1'b1, 1'b0, 1'b0, 1'b0, (i == LIMIT) ? "R3" : "R5");
      idle(3, "R5");

      // R7: writing zero keeps the flag
      step(1'b0, 1'b1, 1'b1, 1'b0, "R7");
      idle(2, "R7");

      // R6: writing one clears the flag
      step(1'b0, 1'b1, 1'b1, 1'b1, "R6");
      idle(2, "R6");

      // R8: host clear on the same edge as the timeout
      for (int i = 0; i < LIMIT + 3; i++)
         step(1'b1, 1'b0, (i == LIMIT), 1'b1, "R8");
      idle(2, "R8");
      step(1'b0, 1'b1, 1'b1, 1'b1, "R6");
      idle(4, "R6");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 50000);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule